// File: doc/BRIEF.md
# DMA Channel Control and Request Logic

This block is the control half of a single DMA channel. Software programs it through two byte-wide control registers on a small register bus. One register holds the mode, the request flag, a two-bit request-source choice, the enable, the transfer size and the two address directions. The other holds a four-bit extended source code. The channel watches one request source at a time. It can be a software strobe, one of two serial-port events, or, through the extended escape code, one of up to ten further event lines. A rising edge on the selected line latches a pending-request flag while the channel is enabled.

While the flag and the enable are both set, the block presents a transfer command to an external transfer engine. The command carries the current source and destination addresses, the transfer size and the per-transfer address steps. The engine acknowledges each finished transfer with a one-cycle done pulse. On that pulse the block clears the flag, steps the address counters and counts down the remaining transfers. It also raises a one-cycle completion pulse, which another channel can use as its own request source.

At the end of a block of transfers, normal mode drops the enable. Ring-buffer mode reloads the base addresses and the count and keeps running. Base addresses and the transfer count come in as configuration inputs. They are loaded whenever software turns the enable on.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset both control registers read 0x00, no command is presented (`cmd_valid` = 0) and `xfer_cplt` is 0.
- R2: Register 0 (`reg_sel` = 0) reads back, from data bit 7 down to bit 0: ring mode, request flag, source select[1:0], enable, byte size, source increment, destination increment. Register 1 (`reg_sel` = 1) keeps the extended code in data bits 3:0. Bits 7:4 of register 1 read 0 whatever is written.
- R3: A register-0 write with the flag bit (data bit 6) at 0 clears the request flag. A write with that bit at 1 leaves the flag as it was.
- R4: Source select 00 takes `sw_start`, 01 takes `ev_ser0_tx`, 10 takes `ev_ser1_rx` and 11 takes the extended event selected by register 1. Only a 0-to-1 transition of the selected line sets the flag, and only while the enable is 1. Unselected lines have no effect. A line held high yields one request.
- R5: Extended codes 0 to 9 select `ev_ext[code]`. Codes 10 to 15 never set the flag.
- R6: `cmd_valid` is the flag ANDed with the enable, so it rises in the cycle after the triggering edge. The step for each address is 0 when its increment bit is 0. Otherwise it is 1 for byte size and 2 for 16-bit size. `cmd_byte` mirrors the size bit.
- R7: `xfer_done` is accepted only while `cmd_valid` is 1. An accepted done clears the flag and adds each step to its address. It also pulses `xfer_cplt` for exactly one cycle, in the cycle after the done. A done pulse without a command changes nothing.
- R8: In normal mode (bit 7 = 0), the done that finishes the programmed count clears the enable. Further events then raise no command.
- R9: In ring mode (bit 7 = 1), the done that finishes the count reloads both base addresses and the count, and the enable stays 1.
- R10: A register-0 write that turns the enable from 0 to 1 loads `cfg_src_base`, `cfg_dst_base` and `cfg_count` into the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 extended source |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sw_start | input | 1 | Software start strobe |
| ev_ser0_tx | input | 1 | Serial port 0 transmit-empty event |
| ev_ser1_rx | input | 1 | Serial port 1 receive event |
| ev_ext | input | NUM_EXT | Extended event lines, indexed by extended code |
| cfg_src_base | input | ADDR_W | Source base address |
| cfg_dst_base | input | ADDR_W | Destination base address |
| cfg_count | input | CNT_W | Transfers per block (nonzero) |
| cmd_valid | output | 1 | Transfer command pending |
| cmd_byte | output | 1 | 1 for byte transfer, 0 for 16-bit |
| cmd_src_addr | output | ADDR_W | Current source address |
| cmd_dst_addr | output | ADDR_W | Current destination address |
| cmd_src_step | output | 2 | Source step after this transfer |
| cmd_dst_step | output | 2 | Destination step after this transfer |
| xfer_done | input | 1 | Engine acknowledge of a finished transfer |
| xfer_cplt | output | 1 | One-cycle transfer-complete pulse |

## Verification
Most results have a one-register latency. An event edge driven before a rising clock edge shows on `cmd_valid` and in the flag bit after that edge. A done pulse shows in the new addresses and in the `xfer_cplt` pulse after the edge that samples it. Register readback is combinational and follows the capturing edge at once. The bench drives every input at a falling edge and samples on the next falling edge, one clock edge later. A driver task pushes the expected post-transfer addresses into a queue each time it sends a done. A monitor pops an entry on every `xfer_cplt` pulse and compares it, so a missing, extra or early completion is caught.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT     = 2'b00,
    SRC_SER0_TX  = 2'b01,
    SRC_SER1_RX  = 2'b10,
    SRC_EXTENDED = 2'b11
  } req_src_e;

  // Control register 0, MSB first
  typedef struct packed {
    logic     ring;
    logic     req;
    req_src_e src;
    logic     en;
    logic     byte_sz;
    logic     src_inc;
    logic     dst_inc;
  } ctl0_t;

  localparam int EXT_W     = 4;
  localparam int EXT_CODES = 1 << EXT_W;
  localparam int FIXED_EV  = 3;

  function automatic logic [1:0] step_of(input logic inc, input logic byte_sz);
    if (!inc)        return 2'd0;
    else if (byte_sz) return 2'd1;
    else              return 2'd2;
  endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             req_hit,
  input  logic             clr_req,
  input  logic             term_clr,
  output ctl0_t            ctl,
  output logic [EXT_W-1:0] ext_sel,
  output logic             load_go,
  output logic [7:0]       reg_rdata
);

  ctl0_t            ctl_q, ctl_d, wval;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic             wr0, wr1, set_req, ctl_ce;

  always_comb begin
    wr0     = reg_we & ~reg_sel;
    wr1     = reg_we & reg_sel;
    wval    = ctl0_t'(reg_wdata);
    set_req = req_hit & ctl_q.en;
    ctl_d   = ctl_q;
    if (term_clr) ctl_d.en  = 1'b0;
    if (clr_req)  ctl_d.req = 1'b0;
    if (wr0) begin
      ctl_d.ring    = wval.ring;
      ctl_d.src     = wval.src;
      ctl_d.en      = wval.en;
      ctl_d.byte_sz = wval.byte_sz;
      ctl_d.src_inc = wval.src_inc;
      ctl_d.dst_inc = wval.dst_inc;
      if (!wval.req) ctl_d.req = 1'b0;
    end
    if (set_req) ctl_d.req = 1'b1;
    ctl_ce  = wr0 | term_clr | clr_req | set_req;
    ext_d   = reg_wdata[EXT_W-1:0];
    load_go = wr0 & wval.en & ~ctl_q.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ext_q <= '0;
    else if (wr1) ext_q <= ext_d;
  end

  assign ctl       = ctl_q;
  assign ext_sel   = ext_q;
  assign reg_rdata = reg_sel ? {{(8-EXT_W){1'b0}}, ext_q} : ctl_q;

  // R3
  req_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wval.req && !ctl_q.req && !(req_hit && ctl_q.en)) |=> !ctl_q.req);

  // R4
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !ctl_q.req) |=> !ctl_q.req);

  // R8
  term_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_clr && !wr0) |=> !ctl_q.en);

endmodule

// File: rtl/dmach_reqsel.sv
module dmach_reqsel
  import dmach_pkg::*;
#(
  parameter int NUM_EXT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  req_src_e           src,
  input  logic [EXT_W-1:0]   ext_sel,
  input  logic               sw_start,
  input  logic               ev_ser0,
  input  logic               ev_ser1,
  input  logic [NUM_EXT-1:0] ev_ext,
  output logic               hit
);

  localparam int NIN = NUM_EXT + FIXED_EV;

  logic [NIN-1:0]       lvl, prev_q, rise;
  logic [EXT_CODES-1:0] ext_rise;
  logic                 ext_ok;

  assign lvl = {ev_ext, ev_ser1, ev_ser0, sw_start};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  for (genvar g = 0; g < EXT_CODES; g++) begin : g_ext
    if (g < NUM_EXT) begin : g_live
      assign ext_rise[g] = rise[g + FIXED_EV];
    end else begin : g_inhib
      assign ext_rise[g] = 1'b0;
    end
  end

  always_comb begin
    ext_ok = int'(ext_sel) < NUM_EXT;
    unique case (src)
      SRC_SOFT:     hit = rise[0];
      SRC_SER0_TX:  hit = rise[1];
      SRC_SER1_RX:  hit = rise[2];
      SRC_EXTENDED: hit = ext_ok & ext_rise[ext_sel];
      default:      hit = 1'b0;
    endcase
  end

  // R5
  ext_inhib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXTENDED && int'(ext_sel) >= NUM_EXT) |-> !hit);

  // R4
  held_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_SER0_TX && ev_ser0) |=> (!ev_ser0 || src != SRC_SER0_TX || !hit));

endmodule

// File: rtl/dmach_addr_ctr.sv
module dmach_addr_ctr
  import dmach_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          inc,
  input  logic          byte_sz,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr,
  output logic [1:0]    step
);

  logic [AW-1:0] addr_q, addr_d;
  logic          ce;

  always_comb begin
    step   = step_of(inc, byte_sz);
    ce     = load | adv;
    addr_d = load ? base : addr_q + AW'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (ce) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> addr_q == $past(addr_q) + AW'($past(step)));

endmodule

// File: rtl/dmach_counters.sv
module dmach_counters
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_go,
  input  logic          adv,
  input  logic          ring,
  input  logic          byte_sz,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [1:0]    src_step,
  output logic [1:0]    dst_step,
  output logic          last
);

  localparam int NCH = 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          reload, ld, adv_only, cnt_ce;
  logic [AW-1:0] base_a [NCH];
  logic [AW-1:0] addr_a [NCH];
  logic          inc_a  [NCH];
  logic [1:0]    step_a [NCH];

  always_comb begin
    last     = cnt_q == CW'(1);
    reload   = adv & last & ring;
    ld       = load_go | reload;
    adv_only = adv & ~reload;
    cnt_ce   = ld | adv_only;
    cnt_d    = ld ? cfg_cnt : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign base_a[0] = cfg_src;
  assign base_a[1] = cfg_dst;
  assign inc_a[0]  = src_inc;
  assign inc_a[1]  = dst_inc;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmach_addr_ctr #(.AW(AW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .adv     (adv_only),
      .inc     (inc_a[g]),
      .byte_sz (byte_sz),
      .base    (base_a[g]),
      .addr    (addr_a[g]),
      .step    (step_a[g])
    );
  end

  assign src_addr = addr_a[0];
  assign dst_addr = addr_a[1];
  assign src_step = step_a[0];
  assign dst_step = step_a[1];

  // R9
  ring_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(cfg_cnt));

  // R10
  load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> cnt_q == $past(cfg_cnt));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dmach_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_EXT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               sw_start,
  input  logic               ev_ser0_tx,
  input  logic               ev_ser1_rx,
  input  logic [NUM_EXT-1:0] ev_ext,
  input  logic [ADDR_W-1:0]  cfg_src_base,
  input  logic [ADDR_W-1:0]  cfg_dst_base,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               cmd_valid,
  output logic               cmd_byte,
  output logic [ADDR_W-1:0]  cmd_src_addr,
  output logic [ADDR_W-1:0]  cmd_dst_addr,
  output logic [1:0]         cmd_src_step,
  output logic [1:0]         cmd_dst_step,
  input  logic               xfer_done,
  output logic               xfer_cplt
);

  logic             rst_meta_q, rst_sync_q;
  ctl0_t            ctl;
  logic [EXT_W-1:0] ext_sel;
  logic             req_hit, load_go, acc, last, term_clr, cplt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dmach_reqsel #(.NUM_EXT(NUM_EXT)) u_reqsel (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .src      (ctl.src),
    .ext_sel  (ext_sel),
    .sw_start (sw_start),
    .ev_ser0  (ev_ser0_tx),
    .ev_ser1  (ev_ser1_rx),
    .ev_ext   (ev_ext),
    .hit      (req_hit)
  );

  dmach_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .req_hit   (req_hit),
    .clr_req   (acc),
    .term_clr  (term_clr),
    .ctl       (ctl),
    .ext_sel   (ext_sel),
    .load_go   (load_go),
    .reg_rdata (reg_rdata)
  );

  dmach_counters #(.AW(ADDR_W), .CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load_go  (load_go),
    .adv      (acc),
    .ring     (ctl.ring),
    .byte_sz  (ctl.byte_sz),
    .src_inc  (ctl.src_inc),
    .dst_inc  (ctl.dst_inc),
    .cfg_src  (cfg_src_base),
    .cfg_dst  (cfg_dst_base),
    .cfg_cnt  (cfg_count),
    .src_addr (cmd_src_addr),
    .dst_addr (cmd_dst_addr),
    .src_step (cmd_src_step),
    .dst_step (cmd_dst_step),
    .last     (last)
  );

  always_comb begin
    cmd_valid = ctl.req & ctl.en;
    cmd_byte  = ctl.byte_sz;
    acc       = xfer_done & cmd_valid;
    term_clr  = acc & last & ~ctl.ring;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) cplt_q <= 1'b0;
    else             cplt_q <= acc;
  end

  assign xfer_cplt = cplt_q;

  // R7
  cplt_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    xfer_cplt |-> $past(xfer_done && cmd_valid));

  // R7
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc && !req_hit) |=> !cmd_valid);

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int NE = 10;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
  } exp_t;

  logic          clk, rst_n;
  logic          reg_we, reg_sel;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          sw_start, ev_ser0_tx, ev_ser1_rx;
  logic [NE-1:0] ev_ext;
  logic [AW-1:0] cfg_src_base, cfg_dst_base;
  logic [CW-1:0] cfg_count;
  logic          cmd_valid, cmd_byte;
  logic [AW-1:0] cmd_src_addr, cmd_dst_addr;
  logic [1:0]    cmd_src_step, cmd_dst_step;
  logic          xfer_done, xfer_cplt;

  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  // bench model of the channel
  logic [AW-1:0] m_src, m_dst;
  int            m_cnt;
  logic          m_ring, m_byte, m_sinc, m_dinc;

  dma_chan_ctl #(.ADDR_W(AW), .CNT_W(CW), .NUM_EXT(NE)) u_dma_chan_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_start(sw_start),
    .ev_ser0_tx(ev_ser0_tx), .ev_ser1_rx(ev_ser1_rx), .ev_ext(ev_ext),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_count(cfg_count), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
    .cmd_src_step(cmd_src_step), .cmd_dst_step(cmd_dst_step),
    .xfer_done(xfer_done), .xfer_cplt(xfer_cplt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // program ctl0 and mirror it in the model; enable 0->1 loads bases
  task automatic prog(input logic [7:0] d, input logic was_en);
    wr(1'b0, d);
    m_ring = d[7]; m_byte = d[2]; m_sinc = d[1]; m_dinc = d[0];
    if (d[3] && !was_en) begin
      m_src = cfg_src_base; m_dst = cfg_dst_base; m_cnt = int'(cfg_count);
    end
  endtask

  function automatic logic [AW-1:0] stp(input logic inc);
    if (!inc) return '0;
    return m_byte ? AW'(1) : AW'(2);
  endfunction

  // driver: acknowledge one command, push expected post-transfer state
  task automatic do_xfer(input string req);
    exp_t e;
    int   w;
    @(negedge clk);
    w = 0;
    while (!cmd_valid && w < 20) begin @(negedge clk); w++; end
    if (!cmd_valid) chk(req, 32'(cmd_valid), 32'd1);
    if (m_cnt == 1 && m_ring) begin
      m_src = cfg_src_base; m_dst = cfg_dst_base; m_cnt = int'(cfg_count);
    end else begin
      m_src = m_src + stp(m_sinc); m_dst = m_dst + stp(m_dinc); m_cnt--;
    end
    e.src = m_src; e.dst = m_dst;
    sb_q.push_back(e);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    @(negedge clk);
    chk({req, " queue drained"}, 32'(sb_q.size()), 32'd0);
  endtask

  // monitor: every completion pulse must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && xfer_cplt) begin
      if (sb_q.size() == 0) begin
        chk("R7 unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R7 src after transfer", 32'(cmd_src_addr), 32'(e.src));
        chk("R7 dst after transfer", 32'(cmd_dst_addr), 32'(e.dst));
      end
    end
  end

  task automatic pulse_sw();
    @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_ext(input logic [NE-1:0] v);
    @(negedge clk); ev_ext = v; @(negedge clk); ev_ext = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    sw_start = 1'b0; ev_ser0_tx = 1'b0; ev_ser1_rx = 1'b0; ev_ext = '0;
    cfg_src_base = '0; cfg_dst_base = '0; cfg_count = '0; xfer_done = 1'b0;
    m_src = '0; m_dst = '0; m_cnt = 0;
    m_ring = 0; m_byte = 0; m_sinc = 0; m_dinc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 ctl0 reset", 32'(d), 32'h00);
    rd(1'b1, d); chk("R1 ctl1 reset", 32'(d), 32'h00);
    chk("R1 no command", 32'(cmd_valid), 32'd0);
    chk("R1 no completion", 32'(xfer_cplt), 32'd0);

    // R4 disabled channel ignores a start
    pulse_sw();
    rd(1'b0, d); chk("R4 no flag while disabled", 32'(d), 32'h00);

    // R10 + R3: enable with flag bit 1 while flag clear
    cfg_src_base = 16'h1000; cfg_dst_base = 16'h2000; cfg_count = 8'd3;
    prog(8'h4A, 1'b0);
    rd(1'b0, d); chk("R3 write 1 keeps clear flag", 32'(d), 32'h0A);
    chk("R10 src loaded", 32'(cmd_src_addr), 32'h1000);
    chk("R10 dst loaded", 32'(cmd_dst_addr), 32'h2000);
    chk("R6 src step word", 32'(cmd_src_step), 32'd2);
    chk("R6 dst step fixed", 32'(cmd_dst_step), 32'd0);
    chk("R6 word size", 32'(cmd_byte), 32'd0);

    // R6 command follows event
    pulse_sw();
    chk("R6 command after start", 32'(cmd_valid), 32'd1);
    rd(1'b0, d); chk("R2 flag bit readback", 32'(d), 32'h4A);
    wr(1'b0, 8'h4A);
    rd(1'b0, d); chk("R3 write 1 keeps set flag", 32'(d), 32'h4A);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R3 write 0 clears flag", 32'(d), 32'h0A);
    chk("R3 command withdrawn", 32'(cmd_valid), 32'd0);

    // R4 unselected source
    @(negedge clk); ev_ser1_rx = 1'b1; @(negedge clk); ev_ser1_rx = 1'b0;
    chk("R4 unselected source ignored", 32'(cmd_valid), 32'd0);

    // R8 normal mode block of three
    for (int i = 0; i < 3; i++) begin
      pulse_sw();
      do_xfer("R8 normal transfer");
    end
    rd(1'b0, d); chk("R8 enable cleared at end", 32'(d), 32'h02);
    pulse_sw();
    chk("R8 no command after end", 32'(cmd_valid), 32'd0);

    // R7 done without command ignored
    @(negedge clk); xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk("R7 stray done no pulse", 32'(xfer_cplt), 32'd0);
    chk("R7 stray done no step", 32'(cmd_src_addr), 32'h1006);

    // R9 ring mode, byte, both increment, serial 0 source
    cfg_src_base = 16'h3000; cfg_dst_base = 16'h4000; cfg_count = 8'd2;
    prog(8'h9F, 1'b0);
    rd(1'b0, d); chk("R2 ring control readback", 32'(d), 32'h9F);
    chk("R6 src step byte", 32'(cmd_src_step), 32'd1);
    chk("R6 dst step byte", 32'(cmd_dst_step), 32'd1);
    chk("R6 byte size", 32'(cmd_byte), 32'd1);
    @(negedge clk); ev_ser0_tx = 1'b1;
    @(negedge clk);
    chk("R4 serial 0 request", 32'(cmd_valid), 32'd1);
    do_xfer("R9 ring transfer");
    chk("R4 held line single request", 32'(cmd_valid), 32'd0);
    ev_ser0_tx = 1'b0;
    @(negedge clk); ev_ser0_tx = 1'b1; @(negedge clk); ev_ser0_tx = 1'b0;
    do_xfer("R9 ring wrap");
    chk("R9 src reloaded", 32'(cmd_src_addr), 32'h3000);
    chk("R9 dst reloaded", 32'(cmd_dst_addr), 32'h4000);
    rd(1'b0, d); chk("R9 still enabled", 32'(d), 32'h9F);
    @(negedge clk); ev_ser0_tx = 1'b1; @(negedge clk); ev_ser0_tx = 1'b0;
    do_xfer("R9 ring continues");

    // R5 extended sources
    prog(8'h00, 1'b1);
    cfg_src_base = 16'h5000; cfg_dst_base = 16'h6000; cfg_count = 8'd4;
    wr(1'b1, 8'hF1);
    rd(1'b1, d); chk("R2 ctl1 upper bits read 0", 32'(d), 32'h01);
    prog(8'h3A, 1'b0);
    pulse_ext(10'h001);
    chk("R5 other extended line ignored", 32'(cmd_valid), 32'd0);
    pulse_ext(10'h002);
    chk("R5 code 1 request", 32'(cmd_valid), 32'd1);
    do_xfer("R5 extended transfer");
    wr(1'b1, 8'h0A);
    pulse_ext(10'h3FF);
    chk("R5 code 10 inhibited", 32'(cmd_valid), 32'd0);
    wr(1'b1, 8'h0F);
    pulse_ext(10'h3FF);
    chk("R5 code 15 inhibited", 32'(cmd_valid), 32'd0);
    wr(1'b1, 8'h09);
    pulse_ext(10'h200);
    chk("R5 code 9 request", 32'(cmd_valid), 32'd1);
    do_xfer("R5 code 9 transfer");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule